// File: doc/BRIEF.md
# Execute-Stage Interrupt Hold

This block sits in the execute stage of a processor pipeline. It decides when an interrupt found in that stage may be handed to writeback.

If the load/store unit is idle when the interrupt is detected, the request goes straight to writeback in the same cycle. If the load/store unit is still working on older instructions, the interrupt is parked in a one-entry pending register, together with its vector. While it is parked, the decode stage is told to stop, and nothing new is accepted for execution. The parked interrupt is released as soon as the load/store unit drains. It is thrown away if the load/store unit reports an interrupt of its own first.

The pending register is the only state in the block. Every output is a direct function of that register and the current inputs, so a request reaches writeback with no added latency.

Top module: `exec_intr_hold`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the pending state. After that edge, `dec_busy` and `wb_irq_req` are 0, even if an interrupt was pending before.
- R2: When nothing is pending, `irq_det` is 1, `lsu_busy` is 0 and `lsu_irq` is 0, `wb_irq_req` is 1 in that same cycle and `wb_irq_vec` equals `irq_vec`. No pending state is created, so `dec_busy` stays 0 in the next cycle.
- R3: When nothing is pending, `irq_det` is 1, `lsu_busy` is 1 and `lsu_irq` is 0, `wb_irq_req` stays 0 in that cycle and `dec_busy` is 1 from the next cycle on.
- R4: While `dec_busy` is 1, `exec_en` is 0 whatever `issue_vld` is. In a cycle where `irq_det` is 1, `exec_en` is also 0.
- R5: While pending, a cycle with `lsu_busy` = 0 and `lsu_irq` = 0 raises `wb_irq_req` in that cycle. `dec_busy` returns to 0 in the next cycle.
- R6: While pending, a cycle with `lsu_irq` = 1 clears the pending state without ever raising `wb_irq_req` for the held interrupt. This holds whether or not `lsu_busy` is 1 in that cycle.
- R7: The vector captured when the interrupt is parked is the one later delivered. A new `irq_det` or a change on `irq_vec` while pending has no effect, and `wb_irq_vec` holds steady throughout the pending period.
- R8: With no pending interrupt and `irq_det` at 0, `exec_en` follows `issue_vld`, and `dec_busy` and `wb_irq_req` are 0.
- R9: When `irq_det` and `lsu_irq` are both 1 while nothing is pending, the detected interrupt is discarded. No request is raised and no pending state is created.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq_det | input | 1 | Interrupt detected in execute this cycle |
| irq_vec | input | VEC_W | Vector of the detected interrupt |
| issue_vld | input | 1 | Decode presents an instruction |
| lsu_busy | input | 1 | Load/store unit still holds earlier instructions |
| lsu_irq | input | 1 | Load/store unit raises its own interrupt |
| dec_busy | output | 1 | Stall request back to decode (pending flag) |
| exec_en | output | 1 | Instruction from decode is accepted for execution |
| wb_irq_req | output | 1 | Interrupt request to writeback |
| wb_irq_vec | output | VEC_W | Vector sent with the writeback request |

## Verification
The bench builds the block with its default `VEC_W` of 12. This width lets distinct vectors such as 0x900 and 0x700 be told apart. A delivery of the wrong vector after an overwrite attempt while pending is therefore visible at `wb_irq_vec`. A vector table walks the block through immediate delivery, deferral with drain, and discard by a load/store interrupt, including the case where draining and the load/store interrupt coincide. Directed steps then cover reset in the middle of a pending period.

// File: rtl/exec_intr_hold.sv
module exec_intr_hold #(
  parameter int VEC_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_det,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             issue_vld,
  input  logic             lsu_busy,
  input  logic             lsu_irq,
  output logic             dec_busy,
  output logic             exec_en,
  output logic             wb_irq_req,
  output logic [VEC_W-1:0] wb_irq_vec
);

  logic             pend_q;
  logic [VEC_W-1:0] vec_q;

  logic take_now, park_now, send_now, rel_now, drop_now;

  assign take_now = irq_det & ~pend_q & ~lsu_irq;
  assign park_now = take_now & lsu_busy;
  assign send_now = take_now & ~lsu_busy;
  assign rel_now  = pend_q & ~lsu_busy & ~lsu_irq;
  assign drop_now = pend_q & lsu_irq;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      if (park_now) begin
        pend_q <= 1'b1;
        vec_q  <= irq_vec;
      end else if (rel_now || drop_now) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign dec_busy   = pend_q;
  assign exec_en    = issue_vld & ~irq_det & ~pend_q;
  assign wb_irq_req = send_now | rel_now;
  assign wb_irq_vec = pend_q ? vec_q : irq_vec;

endmodule

module exec_intr_hold_chk #(
  parameter int VEC_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_det,
  input logic [VEC_W-1:0] irq_vec,
  input logic             lsu_busy,
  input logic             lsu_irq,
  input logic             dec_busy,
  input logic             exec_en,
  input logic             wb_irq_req,
  input logic [VEC_W-1:0] wb_irq_vec
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!dec_busy && !wb_irq_req));

  assert_direct_send_R2: assert property (@(posedge clk) disable iff (rst)
    (!dec_busy && irq_det && !lsu_busy && !lsu_irq) |->
      (wb_irq_req && wb_irq_vec == irq_vec));

  assert_park_sets_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (!dec_busy && irq_det && lsu_busy && !lsu_irq) |-> !wb_irq_req ##1 dec_busy);

  assert_no_issue_while_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (dec_busy || irq_det) |-> !exec_en);

  assert_release_on_drain_R5: assert property (@(posedge clk) disable iff (rst)
    (dec_busy && !lsu_busy && !lsu_irq) |-> wb_irq_req ##1 !dec_busy);

  assert_drop_on_lsu_irq_R6: assert property (@(posedge clk) disable iff (rst)
    (dec_busy && lsu_irq) |-> !wb_irq_req ##1 !dec_busy);

  assert_vec_held_R7: assert property (@(posedge clk) disable iff (rst)
    (dec_busy && $past(dec_busy)) |-> $stable(wb_irq_vec));

  assert_discard_same_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    (!dec_busy && irq_det && lsu_irq) |-> !wb_irq_req ##1 !dec_busy);

endmodule

bind exec_intr_hold exec_intr_hold_chk #(.VEC_W(VEC_W)) chk_i (
  .clk(clk), .rst(rst), .irq_det(irq_det), .irq_vec(irq_vec),
  .lsu_busy(lsu_busy), .lsu_irq(lsu_irq), .dec_busy(dec_busy),
  .exec_en(exec_en), .wb_irq_req(wb_irq_req), .wb_irq_vec(wb_irq_vec)
);

// File: tb/exec_intr_hold_tb_top.sv
module exec_intr_hold_tb_top;
  localparam int CLK_P = 10;
  localparam int VW    = 12;
  localparam int NROW  = 16;
  // row: req(8) det vec(12) vld lsb lsi | busy en wreq wvec(12)
  localparam int RW = 8 + 1 + VW + 3 + 3 + VW;

  localparam logic [RW-1:0] TBL [NROW] = '{
    {8'd8, 1'b0, 12'h000, 3'b100, 3'b010, 12'h000}, // R8 idle, issue passes
    {8'd2, 1'b1, 12'h500, 3'b100, 3'b001, 12'h500}, // R2 direct send
    {8'd2, 1'b0, 12'h000, 3'b100, 3'b010, 12'h000}, // R2 no flag left
    {8'd3, 1'b1, 12'h900, 3'b110, 3'b000, 12'h000}, // R3 park
    {8'd4, 1'b0, 12'h000, 3'b110, 3'b100, 12'h000}, // R4 stalled
    {8'd7, 1'b1, 12'h700, 3'b110, 3'b100, 12'h000}, // R7 new det ignored
    {8'd5, 1'b0, 12'h0AA, 3'b000, 3'b101, 12'h900}, // R5 R7 release held vec
    {8'd5, 1'b0, 12'h000, 3'b100, 3'b010, 12'h000}, // R5 busy gone
    {8'd3, 1'b1, 12'hC00, 3'b010, 3'b000, 12'h000}, // R3 park again
    {8'd6, 1'b0, 12'h000, 3'b011, 3'b100, 12'h000}, // R6 lsu irq drops
    {8'd6, 1'b0, 12'h000, 3'b100, 3'b010, 12'h000}, // R6 flag cleared
    {8'd9, 1'b1, 12'h300, 3'b111, 3'b000, 12'h000}, // R9 same-cycle discard
    {8'd9, 1'b0, 12'h000, 3'b100, 3'b010, 12'h000}, // R9 no flag
    {8'd3, 1'b1, 12'h200, 3'b010, 3'b000, 12'h000}, // R3 park
    {8'd6, 1'b0, 12'h000, 3'b001, 3'b100, 12'h000}, // R6 drain with lsu irq
    {8'd6, 1'b0, 12'h000, 3'b100, 3'b010, 12'h000}  // R6 nothing delivered
  };

  logic clk = 1'b0;
  logic rst;
  logic irq_det, issue_vld, lsu_busy, lsu_irq;
  logic [VW-1:0] irq_vec;
  logic dec_busy, exec_en, wb_irq_req;
  logic [VW-1:0] wb_irq_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  exec_intr_hold #(.VEC_W(VW)) dut_i (
    .clk(clk), .rst(rst), .irq_det(irq_det), .irq_vec(irq_vec),
    .issue_vld(issue_vld), .lsu_busy(lsu_busy), .lsu_irq(lsu_irq),
    .dec_busy(dec_busy), .exec_en(exec_en), .wb_irq_req(wb_irq_req),
    .wb_irq_vec(wb_irq_vec)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic d, input logic [VW-1:0] v, input logic vl,
                       input logic lb, input logic li);
    @(negedge clk);
    irq_det = d; irq_vec = v; issue_vld = vl; lsu_busy = lb; lsu_irq = li;
    #1;
  endtask

  initial begin
    #(CLK_P*2000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; irq_det = 0; irq_vec = '0; issue_vld = 0; lsu_busy = 0; lsu_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
    chk("R1 busy after reset", 32'(dec_busy), 0);
    chk("R1 req after reset", 32'(wb_irq_req), 0);

    for (int i = 0; i < NROW; i++) begin
      logic [RW-1:0] r;
      string tg;
      r = TBL[i];
      drive(r[RW-9], r[RW-10 -: VW], r[VW+5], r[VW+4], r[VW+3]);
      tg = $sformatf("R%0d row%0d", r[RW-1 -: 8], i);
      chk({tg, " busy"}, 32'(dec_busy), 32'(r[VW+2]));
      chk({tg, " exec_en"}, 32'(exec_en), 32'(r[VW+1]));
      chk({tg, " req"}, 32'(wb_irq_req), 32'(r[VW]));
      if (r[VW]) chk({tg, " vec"}, 32'(wb_irq_vec), 32'(r[VW-1:0]));
    end

    // R1: reset while an interrupt is parked
    drive(1, 12'h444, 0, 1, 0);
    drive(0, 12'h000, 1, 1, 0);
    chk("R1 parked before reset", 32'(dec_busy), 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    irq_det = 0; issue_vld = 1; lsu_busy = 0; lsu_irq = 0; #1;
    chk("R1 busy cleared by reset", 32'(dec_busy), 0);
    chk("R1 no stale request", 32'(wb_irq_req), 0);
    chk("R8 issue after reset", 32'(exec_en), 1);

    // R7: vector input changes during a long pending period
    drive(1, 12'h123, 0, 1, 0);
    for (int k = 0; k < 5; k++) begin
      drive(0, 12'(k * 12'h111 + 12'h0F0), 1, 1, 0);
      chk("R4 held stall", 32'(exec_en), 0);
    end
    drive(0, 12'hFFF, 0, 0, 0);
    chk("R7 long hold req", 32'(wb_irq_req), 1);
    chk("R7 long hold vec", 32'(wb_irq_vec), 32'h123);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule